// File: doc/BRIEF.md
# Clock-Synchronous Serial Transmitter with Clock Pin Steering

This block shifts bytes out on a serial data line together with a transfer clock. A CPU-side register interface loads a control word, a transmit buffer, an enable level and an interrupt clear. A written byte waits in the buffer until the transmitter is enabled and the shift register is free. It then moves into the shift register on a falling edge of the transfer clock, and the first bit leaves on that same edge. While the byte shifts out, the CPU can load the next one. A follow-on byte starts on the very next falling edge, so the clock period has no gap between bytes.

The transfer clock is either made internally by dividing the system clock (half-periods of 1, 8 or 32 cycles) or taken from an external clock pin through a synchronizer. The control word also selects the bit order, the clock polarity, whether an active-low clear-to-send input gates the start of a byte, and whether the interrupt request fires when the buffer empties or when the byte completes. An internally generated clock can be steered to an alternate output pin. Fields that shape the clock are locked while a byte is in flight.

Top module: `csync_tx`

## Requirements
- R1: After reset, txd_o=1, clk_pri_o=1, clk_alt_o=1, buf_empty_o=1, tx_empty_o=1 and irq_o=0, with the control word cleared to all zeros.
- R2: While tx_en_i=0, a byte written to the buffer is not sent. buf_empty_o stays 0, tx_empty_o stays 1, and the clock pins do not toggle.
- R3: With an internal source and a stopped clock, a buffer write captured at one clk_i edge makes the clock pin fall at the next clk_i edge. At that edge txd_o carries the first bit, buf_empty_o goes to 1 and tx_empty_o goes to 0.
- R4: Control bit 3 selects the bit order: 0 sends bit 0 first, 1 sends bit 7 first. One bit is sent per data-changing clock edge, eight bits per byte.
- R5: Control bit 2 selects the polarity. With 0, data changes on the pin's falling edge and the pin idles high. With 1, data changes on the pin's rising edge and the pin idles low.
- R6: Control bits [1:0] select the clock source: 00, 01 and 10 give an internal clock with a half-period of 1, 8 and 32 clk_i cycles; 11 takes the clock from ext_clk_i, and both clock pins are then held at 1.
- R7: After the eighth bit's sampling edge, tx_empty_o goes to 1 and the clock stops at its idle level.
- R8: If the buffer is written again before the current byte ends, the next byte starts one half-period after the last sampling edge, with no idle gap.
- R9: Control bit 5 selects the interrupt cause: 0 sets irq_o when a byte leaves the buffer, 1 sets irq_o when a byte completes. irq_o stays set until irq_clr_i.
- R10: Control bit 4 enables clear-to-send. When it is enabled, a byte starts only if cts_ni is low at the moment of transfer. Raising cts_ni during a byte does not stop that byte.
- R11: Control bits [7:6]=11 steer the internal clock to clk_alt_o, but only when the source is internal and clear-to-send is disabled. Otherwise clk_pri_o is used. The pin that is not selected holds 1.
- R12: Writes to control bits [7:6], [2] and [1:0] while the transmitter is not idle are dropped, not deferred. The other control bits update at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_i | input | 8 | Control word: [7:6] pin route, [5] irq on complete, [4] CTS enable, [3] MSB first, [2] polarity, [1:0] source |
| tx_en_i | input | 1 | Transmit enable |
| buf_wr_i | input | 1 | Transmit buffer write strobe |
| buf_data_i | input | 8 | Byte to transmit |
| irq_clr_i | input | 1 | Clears the interrupt request |
| cts_ni | input | 1 | Clear-to-send, active low, asynchronous |
| ext_clk_i | input | 1 | External transfer clock, asynchronous |
| txd_o | output | 1 | Serial data out |
| clk_pri_o | output | 1 | Primary transfer clock pin |
| clk_alt_o | output | 1 | Alternate transfer clock pin |
| buf_empty_o | output | 1 | Transmit buffer empty |
| tx_empty_o | output | 1 | Shift register empty |
| irq_o | output | 1 | Transmit interrupt request |

## Verification
The bench measures the time from the first falling clock edge to the sixteenth sampling edge of two queued bytes. A design that idles between bytes stretches this span past 31 cycles. It writes clock-source and routing fields in the middle of a byte and then checks that the next byte still uses the old divider and the old pin. A design that defers or applies these writes would switch pins or rates. It releases and then raises clear-to-send across a byte boundary. A design that samples the line all the time would truncate the byte or start the second one. Illegal routing requests are also tried, and they must leave the alternate pin quiet.

// File: rtl/csync_tx_pkg.sv
package csync_tx_pkg;

  typedef enum logic [1:0] {
    SRC_DIV_A = 2'b00,
    SRC_DIV_B = 2'b01,
    SRC_DIV_C = 2'b10,
    SRC_EXT   = 2'b11
  } src_e;

  typedef struct packed {
    logic [1:0] route;
    logic       irq_done;
    logic       cts_en;
    logic       msb;
    logic       pol;
    src_e       src;
  } ctl_t;

  localparam logic [1:0] ROUTE_ALT = 2'b11;

endpackage

// File: rtl/csync_tx_sync.sv
module csync_tx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= {STAGES{RST_VAL}};
    else         q_q <= {q_q[STAGES-2:0], d_i};
  end

  assign q_o = q_q[STAGES-1];
endmodule

// File: rtl/csync_tx_clkgen.sv
module csync_tx_clkgen
  import csync_tx_pkg::*;
#(
  parameter int DIV_A = 1,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  src_e src_i,
  input  logic pol_i,
  input  logic ext_s_i,
  input  logic want_fall_i,
  output logic fall_ev_o,
  output logic rise_ev_o,
  output logic ph_o,
  output logic stopped_o
);
  localparam int DIV_MAX = (DIV_A > DIV_B) ? ((DIV_A > DIV_C) ? DIV_A : DIV_C)
                                           : ((DIV_B > DIV_C) ? DIV_B : DIV_C);
  localparam int CW = $clog2(DIV_MAX + 1);

  logic          int_ph_q, stopped_q, ext_ph_q;
  logic [CW-1:0] cnt_q, lim;
  logic          is_ext, tick, ext_lvl;
  logic          int_fall, int_rise, ext_fall, ext_rise;

  always_comb begin
    unique case (src_i)
      SRC_DIV_B: lim = CW'(DIV_B - 1);
      SRC_DIV_C: lim = CW'(DIV_C - 1);
      default:   lim = CW'(DIV_A - 1);
    endcase
  end

  assign is_ext   = (src_i == SRC_EXT);
  assign tick     = (cnt_q == lim);
  assign ext_lvl  = ext_s_i ^ pol_i;
  assign int_fall = !is_ext && int_ph_q && want_fall_i && (stopped_q || tick);
  assign int_rise = !is_ext && !stopped_q && !int_ph_q && tick;
  assign ext_fall = is_ext && ext_ph_q && !ext_lvl;
  assign ext_rise = is_ext && !ext_ph_q && ext_lvl;

  assign fall_ev_o = int_fall | ext_fall;
  assign rise_ev_o = int_rise | ext_rise;
  assign ph_o      = is_ext ? ext_ph_q : int_ph_q;
  assign stopped_o = stopped_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_ph_q <= 1'b1;
    else         ext_ph_q <= ext_lvl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_ph_q  <= 1'b1;
      stopped_q <= 1'b1;
      cnt_q     <= '0;
    end else if (is_ext) begin
      int_ph_q  <= 1'b1;
      stopped_q <= 1'b1;
      cnt_q     <= '0;
    end else if (stopped_q) begin
      cnt_q <= '0;
      if (want_fall_i) begin
        stopped_q <= 1'b0;
        int_ph_q  <= 1'b0;
      end
    end else if (tick) begin
      cnt_q <= '0;
      if (!int_ph_q)        int_ph_q  <= 1'b1;
      else if (want_fall_i) int_ph_q  <= 1'b0;
      else                  stopped_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R7: a stopped internal clock rests high
  a_r7_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_q |-> int_ph_q);

  // R6: internal edges only ever come one half-period apart
  a_r6_half_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_ext && !stopped_q && !tick) |=> $stable(int_ph_q) || $changed(src_i));

endmodule

// File: rtl/csync_tx_shift.sv
module csync_tx_shift #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fall_ev_i,
  input  logic          rise_ev_i,
  input  logic          tx_en_i,
  input  logic          cts_en_i,
  input  logic          cts_s_i,
  input  logic          msb_i,
  input  logic          irq_done_i,
  input  logic          buf_wr_i,
  input  logic [DW-1:0] buf_data_i,
  input  logic          irq_clr_i,
  output logic          want_fall_o,
  output logic          active_o,
  output logic          txd_o,
  output logic          buf_empty_o,
  output logic          irq_o
);
  localparam int RW = $clog2(DW);

  logic [DW-1:0] buf_q, sh_q, ord;
  logic [RW-1:0] rem_q;
  logic          full_q, active_q, txd_q, irq_q;
  logic          start_ok, load, shift, done;

  always_comb begin
    for (int i = 0; i < DW; i++) ord[i] = msb_i ? buf_q[DW-1-i] : buf_q[i];
  end

  // CTS is looked at only here, at the moment of transfer
  assign start_ok    = tx_en_i && full_q && !(cts_en_i && cts_s_i);
  assign want_fall_o = active_q ? (rem_q != '0) : start_ok;
  assign load        = fall_ev_i && !active_q && start_ok;
  assign shift       = fall_ev_i && active_q && (rem_q != '0);
  assign done        = rise_ev_i && active_q && (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      full_q <= 1'b0;
    end else if (buf_wr_i) begin
      buf_q  <= buf_data_i;
      full_q <= 1'b1;
    end else if (load) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      rem_q    <= '0;
      active_q <= 1'b0;
      txd_q    <= 1'b1;
    end else if (load) begin
      txd_q    <= ord[0];
      sh_q     <= {1'b0, ord[DW-1:1]};
      rem_q    <= RW'(DW - 1);
      active_q <= 1'b1;
    end else if (shift) begin
      txd_q <= sh_q[0];
      sh_q  <= {1'b0, sh_q[DW-1:1]};
      rem_q <= rem_q - RW'(1);
    end else if (done) begin
      active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              irq_q <= 1'b0;
    else if ((load && !irq_done_i) || (done && irq_done_i)) irq_q <= 1'b1;
    else if (irq_clr_i)                       irq_q <= 1'b0;
  end

  assign active_o    = active_q;
  assign txd_o       = txd_q;
  assign buf_empty_o = !full_q;
  assign irq_o       = irq_q;

  // R2
  a_r2_hold_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && !active_q) |=> !active_q);
  // R10
  a_r10_cts_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cts_en_i && cts_s_i && !active_q) |=> !active_q);
  // R3
  a_r3_load_frees_buf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_ev_i && !active_q && !buf_wr_i) |=> buf_empty_o);
  // R9
  a_r9_irq_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && irq_done_i) |=> irq_o);

endmodule

// File: rtl/csync_tx_route.sv
module csync_tx_route
  import csync_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ph_i,
  input  logic       pol_i,
  input  logic       is_ext_i,
  input  logic       cts_en_i,
  input  logic [1:0] route_i,
  output logic       clk_pri_o,
  output logic       clk_alt_o
);
  logic pin, alt_sel;

  assign pin       = ph_i ^ pol_i;
  assign alt_sel   = (route_i == ROUTE_ALT) && !is_ext_i && !cts_en_i;
  assign clk_pri_o = (is_ext_i || alt_sel) ? 1'b1 : pin;
  assign clk_alt_o = alt_sel ? pin : 1'b1;

  // R11: unselected or illegally routed alternate pin never moves
  a_r11_alt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ext_i || cts_en_i || route_i != ROUTE_ALT) |-> clk_alt_o);
  // R6: external source leaves both pins high
  a_r6_ext_pins_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ext_i |-> (clk_pri_o && clk_alt_o));

endmodule

// File: rtl/csync_tx.sv
module csync_tx
  import csync_tx_pkg::*;
#(
  parameter int DW          = 8,
  parameter int DIV_A       = 1,
  parameter int DIV_B       = 8,
  parameter int DIV_C       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_wr_i,
  input  logic [7:0]    ctl_i,
  input  logic          tx_en_i,
  input  logic          buf_wr_i,
  input  logic [DW-1:0] buf_data_i,
  input  logic          irq_clr_i,
  input  logic          cts_ni,
  input  logic          ext_clk_i,
  output logic          txd_o,
  output logic          clk_pri_o,
  output logic          clk_alt_o,
  output logic          buf_empty_o,
  output logic          tx_empty_o,
  output logic          irq_o
);
  ctl_t ctl_q, ctl_n;
  logic cts_s, ext_s;
  logic fall_ev, rise_ev, ph, stopped, want_fall, active, idle;

  assign ctl_n = ctl_t'(ctl_i);
  assign idle  = !active && ((ctl_q.src == SRC_EXT) || stopped);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (ctl_wr_i) begin
      ctl_q.irq_done <= ctl_n.irq_done;
      ctl_q.cts_en   <= ctl_n.cts_en;
      ctl_q.msb      <= ctl_n.msb;
      if (idle) begin
        ctl_q.route <= ctl_n.route;
        ctl_q.pol   <= ctl_n.pol;
        ctl_q.src   <= ctl_n.src;
      end
    end
  end

  csync_tx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cts_ni), .q_o(cts_s));

  csync_tx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_clk_i), .q_o(ext_s));

  csync_tx_clkgen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_clkgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (ctl_q.src),
    .pol_i      (ctl_q.pol),
    .ext_s_i    (ext_s),
    .want_fall_i(want_fall),
    .fall_ev_o  (fall_ev),
    .rise_ev_o  (rise_ev),
    .ph_o       (ph),
    .stopped_o  (stopped)
  );

  csync_tx_shift #(.DW(DW)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_ev_i  (fall_ev),
    .rise_ev_i  (rise_ev),
    .tx_en_i    (tx_en_i),
    .cts_en_i   (ctl_q.cts_en),
    .cts_s_i    (cts_s),
    .msb_i      (ctl_q.msb),
    .irq_done_i (ctl_q.irq_done),
    .buf_wr_i   (buf_wr_i),
    .buf_data_i (buf_data_i),
    .irq_clr_i  (irq_clr_i),
    .want_fall_o(want_fall),
    .active_o   (active),
    .txd_o      (txd_o),
    .buf_empty_o(buf_empty_o),
    .irq_o      (irq_o)
  );

  csync_tx_route u_route (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ph_i     (ph),
    .pol_i    (ctl_q.pol),
    .is_ext_i (ctl_q.src == SRC_EXT),
    .cts_en_i (ctl_q.cts_en),
    .route_i  (ctl_q.route),
    .clk_pri_o(clk_pri_o),
    .clk_alt_o(clk_alt_o)
  );

  assign tx_empty_o = !active;

  // R12: clock-shaping fields frozen while busy
  a_r12_fields_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle |=> ($stable(ctl_q.src) && $stable(ctl_q.pol) && $stable(ctl_q.route)));

endmodule

// File: tb/csync_tx_tb_top.sv
module csync_tx_tb_top;
  localparam int WD = 150000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctl_wr_i = 1'b0;
  logic [7:0] ctl_i = '0;
  logic       tx_en_i = 1'b1;
  logic       buf_wr_i = 1'b0;
  logic [7:0] buf_data_i = '0;
  logic       irq_clr_i = 1'b0;
  logic       cts_ni = 1'b0;
  logic       ext_clk_i = 1'b1;
  logic       txd_o, clk_pri_o, clk_alt_o, buf_empty_o, tx_empty_o, irq_o;

  csync_tx dut_i (.*);

  always #2 clk_i = ~clk_i;

  int   n_chk = 0, n_bad = 0, cyc = 0;
  logic use_alt = 0, cur_pol = 0, rx_arm = 0, obs, obs_prev = 1;
  logic pri_low = 0, alt_low = 0, seen_fall = 0;
  logic [15:0] rx = '0;
  int   rx_cnt = 0, rx_want = 8, t_fall0 = 0, t_rise0 = 0, t_last = 0;

  // {data[7:0], src[1:0], pol, msb}
  localparam logic [11:0] VEC [0:7] = '{
    {8'hA5, 2'b00, 1'b0, 1'b0}, {8'h3C, 2'b00, 1'b0, 1'b1},
    {8'h81, 2'b01, 1'b0, 1'b0}, {8'h5E, 2'b01, 1'b1, 1'b0},
    {8'hC7, 2'b10, 1'b0, 1'b1}, {8'h12, 2'b00, 1'b1, 1'b1},
    {8'hF0, 2'b01, 1'b0, 1'b1}, {8'h0F, 2'b10, 1'b1, 1'b0}};

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == WD) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cyc=%0d expected < %0d", cyc, WD);
      summary();
      $finish;
    end
  end

  // receiver: samples txd on the edge that restores the idle level
  always @(negedge clk_i) begin
    obs = (use_alt ? clk_alt_o : clk_pri_o) ^ cur_pol;
    if (rx_arm) begin
      if (obs_prev && !obs && !seen_fall) begin t_fall0 = cyc; seen_fall = 1; end
      if (!obs_prev && obs && rx_cnt < rx_want) begin
        rx = {txd_o, rx[15:1]};
        if (rx_cnt == 0) t_rise0 = cyc;
        t_last = cyc;
        rx_cnt++;
      end
    end
    obs_prev = obs;
    if (!clk_pri_o) pri_low = 1;
    if (!clk_alt_o) alt_low = 1;
  end

  function automatic logic [7:0] rev8(input logic [7:0] d);
    for (int i = 0; i < 8; i++) rev8[i] = d[7-i];
  endfunction

  function automatic int div_of(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 8 : 32;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [7:0] v);
    @(negedge clk_i); ctl_wr_i = 1; ctl_i = v;
    @(negedge clk_i); ctl_wr_i = 0;
  endtask

  task automatic put_byte(input logic [7:0] d);
    @(negedge clk_i); buf_wr_i = 1; buf_data_i = d;
    @(negedge clk_i); buf_wr_i = 0;
  endtask

  task automatic arm(input int n);
    @(negedge clk_i);
    rx_arm = 0; rx_cnt = 0; rx_want = n; seen_fall = 0; rx = '0;
    @(negedge clk_i);
    rx_arm = 1;
  endtask

  task automatic wait_rx(input int n, input int tmo);
    for (int k = 0; k < tmo && rx_cnt < n; k++) @(negedge clk_i);
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic [7:0] rx_byte();
    return rx[15:8];
  endfunction

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(txd_o && clk_pri_o && clk_alt_o, "R1 pins idle", {txd_o, clk_pri_o, clk_alt_o}, 3'b111);
    chk(buf_empty_o && tx_empty_o && !irq_o, "R1 flags", {buf_empty_o, tx_empty_o, irq_o}, 3'b110);
    rst_ni = 1;
    idle_wait(3);

    // vector walk: R4 order, R5 polarity, R6 dividers, R7 idle
    for (int v = 0; v < 8; v++) begin
      logic [7:0] d;
      logic [1:0] s;
      logic p, m;
      {d, s, p, m} = VEC[v];
      ctl_write({2'b00, 1'b0, 1'b0, m, p, s});
      cur_pol = p; use_alt = 0;
      arm(8);
      put_byte(d);
      wait_rx(8, 2000);
      chk(rx_byte() == (m ? rev8(d) : d), "R4/R5 byte", rx_byte(), m ? rev8(d) : d);
      chk(t_rise0 - t_fall0 == div_of(s), "R6 half period", t_rise0 - t_fall0, div_of(s));
      idle_wait(3 * div_of(s) + 4);
      chk(tx_empty_o && clk_pri_o == !p, "R7 stop at idle level",
          {tx_empty_o, clk_pri_o}, {1'b1, !p});
    end

    // R3 exact transfer timing
    ctl_write(8'h00); cur_pol = 0;
    idle_wait(4);
    put_byte(8'h6D);
    chk(!buf_empty_o && clk_pri_o && tx_empty_o, "R3 before transfer",
        {buf_empty_o, clk_pri_o, tx_empty_o}, 3'b011);
    @(negedge clk_i);
    chk(!clk_pri_o && txd_o == 1'b1, "R3 first edge and bit", {clk_pri_o, txd_o}, 2'b01);
    chk(buf_empty_o && !tx_empty_o, "R3 buffer freed", {buf_empty_o, tx_empty_o}, 2'b10);
    idle_wait(30);

    // R8 back-to-back without gap
    arm(16);
    put_byte(8'h4B);
    for (int k = 0; k < 50 && !buf_empty_o; k++) @(negedge clk_i);
    put_byte(8'hD2);
    wait_rx(16, 500);
    chk(rx == 16'hD24B, "R8 two bytes", rx, 16'hD24B);
    chk(t_last - t_fall0 == 31, "R8 no idle gap", t_last - t_fall0, 31);
    idle_wait(10);

    // R2 enable gate
    tx_en_i = 0;
    arm(8);
    put_byte(8'h39);
    idle_wait(40);
    chk(!buf_empty_o && tx_empty_o && rx_cnt == 0, "R2 held while disabled",
        {buf_empty_o, tx_empty_o, 8'(rx_cnt)}, 10'h100);
    tx_en_i = 1;
    wait_rx(8, 200);
    chk(rx_byte() == 8'h39, "R2 sent after enable", rx_byte(), 8'h39);
    idle_wait(10);

    // R10 CTS gating, sampled only at transfer
    ctl_write(8'h10); cts_ni = 1;
    arm(8);
    put_byte(8'hA6);
    idle_wait(40);
    chk(tx_empty_o && rx_cnt == 0, "R10 blocked by CTS high", {tx_empty_o, 8'(rx_cnt)}, 9'h100);
    cts_ni = 0;
    for (int k = 0; k < 20 && tx_empty_o; k++) @(negedge clk_i);
    idle_wait(4);
    cts_ni = 1;
    wait_rx(8, 200);
    chk(rx_byte() == 8'hA6, "R10 byte completes after CTS rise", rx_byte(), 8'hA6);
    arm(8);
    put_byte(8'h5A);
    idle_wait(40);
    chk(tx_empty_o && !buf_empty_o, "R10 next byte waits", {tx_empty_o, buf_empty_o}, 2'b10);
    cts_ni = 0;
    wait_rx(8, 200);
    chk(rx_byte() == 8'h5A, "R10 sent after CTS low", rx_byte(), 8'h5A);
    idle_wait(10);

    // R9 interrupt cause
    ctl_write(8'h00);
    @(negedge clk_i); irq_clr_i = 1; @(negedge clk_i); irq_clr_i = 0;
    put_byte(8'h77);
    @(negedge clk_i);
    chk(irq_o && !tx_empty_o, "R9 irq on buffer empty", {irq_o, tx_empty_o}, 2'b10);
    idle_wait(30);
    ctl_write(8'h20);
    @(negedge clk_i); irq_clr_i = 1; @(negedge clk_i); irq_clr_i = 0;
    put_byte(8'h88);
    idle_wait(4);
    chk(!irq_o && !tx_empty_o, "R9 no irq mid byte", {irq_o, tx_empty_o}, 2'b00);
    idle_wait(30);
    chk(irq_o && tx_empty_o, "R9 irq on complete", {irq_o, tx_empty_o}, 2'b11);
    @(negedge clk_i); irq_clr_i = 1; @(negedge clk_i); irq_clr_i = 0;
    chk(!irq_o, "R9 irq cleared", irq_o, 0);

    // R12 clock fields dropped while busy
    ctl_write(8'h01); use_alt = 0; cur_pol = 0;
    arm(8);
    alt_low = 0;
    put_byte(8'h6B);
    idle_wait(20);
    ctl_write(8'hC2);
    wait_rx(8, 500);
    chk(rx_byte() == 8'h6B && !alt_low, "R12 route write mid byte ignored",
        {rx_byte(), alt_low}, {8'h6B, 1'b0});
    idle_wait(40);
    arm(8);
    put_byte(8'h94);
    wait_rx(8, 500);
    chk(t_rise0 - t_fall0 == 8 && !alt_low, "R12 source kept after busy write",
        t_rise0 - t_fall0, 8);
    idle_wait(40);

    // R11 legal and illegal routing
    ctl_write(8'hC0); use_alt = 1;
    arm(8);
    pri_low = 0;
    put_byte(8'h2D);
    wait_rx(8, 200);
    chk(rx_byte() == 8'h2D && !pri_low, "R11 alternate pin only",
        {rx_byte(), pri_low}, {8'h2D, 1'b0});
    idle_wait(10);
    ctl_write(8'hD0); use_alt = 0;
    arm(8);
    alt_low = 0;
    put_byte(8'h71);
    wait_rx(8, 200);
    chk(rx_byte() == 8'h71 && !alt_low, "R11 illegal route stays primary",
        {rx_byte(), alt_low}, {8'h71, 1'b0});
    idle_wait(10);

    // R6 external clock source
    ctl_write(8'h0B);
    idle_wait(4);
    pri_low = 0; alt_low = 0;
    put_byte(8'hB4);
    idle_wait(4);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      ext_clk_i = 0; idle_wait(6);
      got[7-i] = txd_o;
      ext_clk_i = 1; idle_wait(6);
    end
    idle_wait(6);
    chk(got == 8'hB4, "R6 external clock MSB first", got, 8'hB4);
    chk(tx_empty_o && !pri_low && !alt_low, "R6 pins held high on external",
        {tx_empty_o, pri_low, alt_low}, 3'b100);

    summary();
    $finish;
  end
endmodule